// File: doc/BRIEF.md
# Write-Only Two-Wire Command and Data Receiver

This block is a target on a two-wire serial bus (I2C, up to 400 kbit/s) that only accepts writes. It feeds a character display controller. A host addresses it, then sends a stream of bytes. The block sorts these bytes into control bytes and payload bytes. Each payload byte comes out as a one-cycle write strobe with an 8-bit value and a register-select flag. The flag tells the command decoder downstream whether the byte is a command or display RAM data.

The bus lines are sampled by the system clock through synchronising flops. START and STOP are seen as edges on the data line while the clock line is high. The block never drives data back to the host. Its only output on the bus is the acknowledge pin: a high level there means "pull SDA low". The acknowledge does not depend on whether the downstream logic is busy. Address pointer handling and command decoding belong to the decoder that consumes the strobes.

Top module: `lcd_i2c_wr_rx`

## Requirements
- R1: After reset, sda_ack_o and wr_stb_o are low.
- R2: A falling SDA while SCL is high starts a transfer, and a rising SDA while SCL is high ends it. After a STOP, clocked bytes are neither acknowledged nor strobed until the next START.
- R3: The first byte after START is taken MSB first as a 7-bit address followed by a direction bit. When the address equals slave_addr_i and the direction bit is 0 (write), the byte is acknowledged. sda_ack_o goes high after the SCL fall that ends bit eight, and it drops after the SCL fall that ends the ninth clock.
- R4: An address mismatch or a direction bit of 1 gives no acknowledge. The block then ignores all bytes, without acknowledge or strobe, until the next START.
- R5: In a control byte, bit 7 is the continuation flag. When it is 1, exactly one payload byte follows, and the byte after that is again a control byte.
- R6: When the continuation flag of a control byte is 0, every later byte up to STOP or START is payload.
- R7: wr_rs_o equals bit 6 of the control byte that governs the payload byte. Bits 5 to 0 of a control byte have no effect.
- R8: Each payload byte produces exactly one wr_stb_o pulse lasting one cycle, with wr_data_o holding the byte. Control and address bytes give no pulse. wr_data_o and wr_rs_o hold their values between pulses.
- R9: After a matching address, every byte is acknowledged, whatever its content.
- R10: A repeated START in the middle of a transfer returns the block to the address phase and drops any pending control state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, at least 20x the bus bit rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| slave_addr_i | input | 7 | Own bus address |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_ack_o | output | 1 | High pulls SDA low to acknowledge |
| wr_stb_o | output | 1 | One-cycle write strobe per payload byte |
| wr_data_o | output | 8 | Payload byte |
| wr_rs_o | output | 1 | Register select: 0 command, 1 display RAM data |

## Verification
The bench first targets how bytes are sorted. It mixes control bytes with the continuation flag at 1 and at 0, and it sets the ignored low bits. A design that swapped the flag meaning or took RS from the wrong bit would strobe control bytes as data or report the wrong register select. The bench also covers mismatched addresses, read-direction addresses and bytes clocked after a STOP. A design that did not drop into its ignore state would acknowledge or strobe them. Finally, a repeated START is placed right after a payload byte, and the next control byte must govern the following data. A design that kept stale continuation state would mislabel that data.

// File: rtl/lcd_i2c_pkg.sv
package lcd_i2c_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 7;
  localparam int unsigned CNT_W  = $clog2(BYTE_W + 1);
  localparam int unsigned CO_BIT = 7;
  localparam int unsigned RS_BIT = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CTRL,
    ST_DATA,
    ST_SKIP
  } rx_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int unsigned NLINES = 2;

  logic [NLINES-1:0] line_in;
  logic [NLINES-1:0] line_s;
  logic [NLINES-1:0] line_q;

  assign line_in = {sda_i, scl_i};

  for (genvar l = 0; l < NLINES; l++) begin : g_line
    logic [SYNC_STAGES-1:0] pipe;
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe <= '1;
        else         pipe <= line_in[l];
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe <= '1;
        else         pipe <= {pipe[SYNC_STAGES-2:0], line_in[l]};
      end
    end
    assign line_s[l] = pipe[SYNC_STAGES-1];

    // previous synced value for edge detection
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) line_q[l] <= 1'b1;
      else         line_q[l] <= line_s[l];
    end
  end

  assign scl_o      = line_s[0];
  assign sda_o      = line_s[1];
  assign scl_rise_o = line_s[0] & ~line_q[0];
  assign scl_fall_o = ~line_s[0] & line_q[0];
  assign start_o    = line_s[0] & line_q[0] & line_q[1] & ~line_s[1];
  assign stop_o     = line_s[0] & line_q[0] & ~line_q[1] & line_s[1];
endmodule

// File: rtl/i2c_bit_shifter.sv
module i2c_bit_shifter
  import lcd_i2c_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_done_o,
  output logic              ack_end_o
);
  logic [CNT_W-1:0]  cnt_q;
  logic              in_ack_q;
  logic [BYTE_W-1:0] shreg_q;
  logic              full;

  assign full        = (cnt_q == CNT_W'(BYTE_W));
  assign byte_done_o = scl_fall_i & full & ~in_ack_q;
  assign ack_end_o   = scl_fall_i & in_ack_q;
  assign byte_o      = shreg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      in_ack_q <= 1'b0;
      shreg_q  <= '0;
    end else if (clr_i) begin
      cnt_q    <= '0;
      in_ack_q <= 1'b0;
    end else begin
      if (scl_rise_i && !in_ack_q && !full) begin
        shreg_q <= {shreg_q[BYTE_W-2:0], sda_i};
        cnt_q   <= cnt_q + 1'b1;
      end
      if (byte_done_o) begin
        in_ack_q <= 1'b1;
      end else if (ack_end_o) begin
        in_ack_q <= 1'b0;
        cnt_q    <= '0;
      end
    end
  end
endmodule

// File: rtl/i2c_stream_fsm.sv
module i2c_stream_fsm
  import lcd_i2c_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] slave_addr_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              byte_done_i,
  input  logic              ack_end_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              ack_o,
  output logic              wr_stb_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              wr_rs_o
);
  rx_state_e state_q;
  logic      co_q;
  logic      rs_q;
  logic      addr_ok;

  // write direction is bit 0 low
  assign addr_ok = (byte_i[BYTE_W-1:1] == slave_addr_i) & ~byte_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      co_q      <= 1'b0;
      rs_q      <= 1'b0;
      ack_o     <= 1'b0;
      wr_stb_o  <= 1'b0;
      wr_data_o <= '0;
      wr_rs_o   <= 1'b0;
    end else begin
      wr_stb_o <= 1'b0;
      if (start_i) begin
        state_q <= ST_ADDR;
        ack_o   <= 1'b0;
      end else if (stop_i) begin
        state_q <= ST_IDLE;
        ack_o   <= 1'b0;
      end else begin
        if (ack_end_i) ack_o <= 1'b0;
        if (byte_done_i) begin
          unique case (state_q)
            ST_ADDR: begin
              ack_o   <= addr_ok;
              state_q <= addr_ok ? ST_CTRL : ST_SKIP;
            end
            ST_CTRL: begin
              ack_o   <= 1'b1;
              co_q    <= byte_i[CO_BIT];
              rs_q    <= byte_i[RS_BIT];
              state_q <= ST_DATA;
            end
            ST_DATA: begin
              ack_o     <= 1'b1;
              wr_stb_o  <= 1'b1;
              wr_data_o <= byte_i;
              wr_rs_o   <= rs_q;
              if (co_q) state_q <= ST_CTRL;
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/lcd_i2c_wr_rx.sv
module lcd_i2c_wr_rx
  import lcd_i2c_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] slave_addr_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_ack_o,
  output logic              wr_stb_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              wr_rs_o
);
  logic              scl_s;
  logic              sda_s;
  logic              scl_rise;
  logic              scl_fall;
  logic              start_det;
  logic              stop_det;
  logic [BYTE_W-1:0] rx_byte;
  logic              byte_done;
  logic              ack_end;

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_o     (scl_s),
    .sda_o     (sda_s),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_det),
    .stop_o    (stop_det)
  );

  i2c_bit_shifter u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (start_det | stop_det),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .sda_i      (sda_s),
    .byte_o     (rx_byte),
    .byte_done_o(byte_done),
    .ack_end_o  (ack_end)
  );

  i2c_stream_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .slave_addr_i(slave_addr_i),
    .start_i     (start_det),
    .stop_i      (stop_det),
    .byte_done_i (byte_done),
    .ack_end_i   (ack_end),
    .byte_i      (rx_byte),
    .ack_o       (sda_ack_o),
    .wr_stb_o    (wr_stb_o),
    .wr_data_o   (wr_data_o),
    .wr_rs_o     (wr_rs_o)
  );
endmodule

// File: rtl/lcd_i2c_wr_rx_chk.sv
module lcd_i2c_wr_rx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_s,
  input logic       stop_det,
  input logic       sda_ack_o,
  input logic       wr_stb_o,
  input logic [7:0] wr_data_o,
  input logic       wr_rs_o
);
  // R8
  stb_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |=> !wr_stb_o);

  // R9
  stb_acked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |-> sda_ack_o);

  // R3
  ack_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_ack_o) |-> !scl_s);

  // R2
  stop_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !sda_ack_o);

  // R8
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_stb_o |-> ($stable(wr_data_o) && $stable(wr_rs_o)));
endmodule

bind lcd_i2c_wr_rx lcd_i2c_wr_rx_chk u_chk (.*);

// File: tb/lcd_i2c_wr_rx_tb.sv
module lcd_i2c_wr_rx_tb;
  localparam int Q = 8;
  localparam logic [6:0] OWN = 7'h3C;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_line;
  logic       sda_ack_o;
  logic       wr_stb_o;
  logic [7:0] wr_data_o;
  logic       wr_rs_o;

  int checks = 0;
  int errors = 0;

  logic [7:0] tx [0:15];
  logic       exp_ack [0:15];
  logic [7:0] exp_d [0:15];
  logic       exp_rs [0:15];
  int         exp_n;
  logic       exp_match;
  logic [7:0] got_d [0:63];
  logic       got_rs [0:63];
  int         got_n = 0;

  always #5 clk = ~clk;
  assign sda_line = sda_m & ~sda_ack_o;

  lcd_i2c_wr_rx u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .slave_addr_i(OWN),
    .scl_i       (scl_m),
    .sda_i       (sda_line),
    .sda_ack_o   (sda_ack_o),
    .wr_stb_o    (wr_stb_o),
    .wr_data_o   (wr_data_o),
    .wr_rs_o     (wr_rs_o)
  );

  always @(negedge clk) begin
    if (rst_ni && wr_stb_o) begin
      if (got_n < 64) begin
        got_d[got_n]  = wr_data_o;
        got_rs[got_n] = wr_rs_o;
      end
      got_n = got_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wclk(Q);
    scl_m = 1'b1; wclk(Q);
    sda_m = 1'b0; wclk(Q);
    scl_m = 1'b0; wclk(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wclk(Q);
    scl_m = 1'b1; wclk(Q);
    sda_m = 1'b1; wclk(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wclk(Q);
      scl_m = 1'b1; wclk(2*Q);
      scl_m = 1'b0; wclk(Q);
    end
    sda_m = 1'b1; wclk(Q);
    scl_m = 1'b1; wclk(Q);
    acked = sda_ack_o;
    wclk(Q);
    scl_m = 1'b0; wclk(Q);
  endtask

  // reference model of byte sorting
  task automatic model(input int n);
    logic ctrl_ph, co, rs;
    ctrl_ph = 1'b1; co = 1'b0; rs = 1'b0;
    exp_n = 0;
    exp_match = (tx[0][7:1] == OWN) && !tx[0][0];
    exp_ack[0] = exp_match;
    for (int i = 1; i < n; i++) begin
      exp_ack[i] = exp_match;
      if (exp_match) begin
        if (ctrl_ph) begin
          co = tx[i][7]; rs = tx[i][6]; ctrl_ph = 1'b0;
        end else begin
          exp_d[exp_n] = tx[i]; exp_rs[exp_n] = rs; exp_n++;
          if (co) ctrl_ph = 1'b1;
        end
      end
    end
  endtask

  task automatic compare_strobes(input int base);
    chk(got_n - base == exp_n, "R5 R6 R8 strobe count", got_n - base, exp_n);
    for (int i = 0; i < exp_n; i++) begin
      if (base + i < got_n && base + i < 64) begin
        chk(got_d[base+i] == exp_d[i], "R8 data", got_d[base+i], exp_d[i]);
        chk(got_rs[base+i] == exp_rs[i], "R7 rs", got_rs[base+i], exp_rs[i]);
      end
    end
  endtask

  task automatic run_txn(input int n);
    logic a;
    int base;
    model(n);
    base = got_n;
    bus_start();
    for (int i = 0; i < n; i++) begin
      send_byte(tx[i], a);
      if (i == 0) chk(a == exp_ack[0], exp_match ? "R3 addr ack" : "R4 addr nack", a, exp_ack[0]);
      else        chk(a == exp_ack[i], exp_match ? "R9 byte ack" : "R4 ignored byte", a, exp_ack[i]);
    end
    bus_stop();
    wclk(10);
    compare_strobes(base);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic a;
    int base;
    void'($urandom(32'h5eed_0036));
    wclk(4);
    // R1
    chk(sda_ack_o == 1'b0, "R1 ack after reset", sda_ack_o, 0);
    chk(wr_stb_o == 1'b0, "R1 stb after reset", wr_stb_o, 0);
    rst_ni = 1'b1;
    wclk(4);

    // R5: continuation chain, R7: low bits set
    tx[0] = {OWN, 1'b0}; tx[1] = 8'hBF; tx[2] = 8'h55; tx[3] = 8'hC0; tx[4] = 8'hA6;
    tx[5] = 8'h3F; tx[6] = 8'h12; tx[7] = 8'h34;
    run_txn(8);

    // R6: stream of data after co=0 with RS=1
    tx[0] = {OWN, 1'b0}; tx[1] = 8'h7F; tx[2] = 8'h80; tx[3] = 8'hC1; tx[4] = 8'h00; tx[5] = 8'hFF;
    run_txn(6);

    // R4: wrong address, then read direction
    tx[0] = {OWN ^ 7'h01, 1'b0}; tx[1] = 8'h40; tx[2] = 8'h99; tx[3] = 8'h77;
    run_txn(4);
    tx[0] = {OWN, 1'b1}; tx[1] = 8'h00; tx[2] = 8'h42;
    run_txn(3);

    // R2: bytes clocked after STOP are ignored
    tx[0] = {OWN, 1'b0}; tx[1] = 8'h00; tx[2] = 8'h11;
    run_txn(3);
    base = got_n;
    send_byte(8'h22, a);
    chk(a == 1'b0, "R2 no ack after stop", a, 0);
    send_byte(8'h00, a);
    wclk(10);
    chk(got_n == base, "R2 no strobe after stop", got_n - base, 0);
    sda_m = 1'b1; wclk(Q); scl_m = 1'b1; wclk(2*Q);

    // R10: repeated START after a data byte under co=0
    base = got_n;
    bus_start();
    send_byte({OWN, 1'b0}, a);
    send_byte(8'h40, a);
    send_byte(8'hA1, a);
    bus_start();
    send_byte({OWN, 1'b0}, a);
    chk(a == 1'b1, "R10 addr ack after repeated start", a, 1);
    send_byte(8'h80, a);
    send_byte(8'hB2, a);
    send_byte(8'h40, a);
    send_byte(8'hC3, a);
    bus_stop();
    wclk(10);
    exp_n = 3;
    exp_d[0] = 8'hA1; exp_rs[0] = 1'b1;
    exp_d[1] = 8'hB2; exp_rs[1] = 1'b0;
    exp_d[2] = 8'hC3; exp_rs[2] = 1'b1;
    compare_strobes(base);

    // random transfers
    for (int t = 0; t < 20; t++) begin
      int n;
      n = 1 + int'($urandom_range(9));
      tx[0] = ($urandom_range(3) != 0) ? {OWN, 1'b0} : 8'($urandom);
      for (int i = 1; i < n; i++) tx[i] = 8'($urandom);
      run_txn(n);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule